// File: doc/BRIEF.md
# Programmable Dual-Tone Generator

This block makes two digital square-wave tones from a fixed 1.2 MHz system clock. Each tone has its own 8-bit divisor register, loaded from a shared data bus with one write strobe per register. The high tone divides the clock by six times its divisor. The low tone divides it by fourteen times its divisor. Each square wave toggles after half of its full divide count. A toggle point counts as the tone's reference-level crossing. The two sign bits are also summed into a 2-bit level word, for a later stage that shapes and filters the signal.

A write to the low-tone register starts both tones and (re)loads a burst timer of 96 ms, which is 115200 clock cycles. When the timer has run out, each tone keeps going until its own next toggle point, then stops with its sign output low. A continuous-mode input keeps the tones running regardless of the timer. Some divisor codes are special: one code silences a tone, which allows single-tone operation, and two codes select the longest period. Rewriting a divisor while a tone runs changes the pitch without restarting the waveform.

Top module: `dual_tone_gen`

## Requirements
- R1: With high divisor code H in 3..255, `toneHi` toggles every 3*H clock cycles (period 6*H), the first toggle coming 3*H cycles after the edge that samples the starting low-register write.
- R2: With low divisor code L in 3..255, `toneLo` toggles every 7*L clock cycles (period 14*L), timed from the same starting write edge.
- R3: A write to the high register never starts the tones. A write to the low register starts any idle tone and reloads a burst of BURST_CYCLES cycles (default 115200). The burst covers the edges up to and including BURST_CYCLES after the write edge.
- R4: Once the burst has ended and continuous mode is low, each running tone stops at its next toggle point instead of toggling. Its sign output becomes 0 and stays 0.
- R5: While `contMode` is 1, tones keep toggling after the burst has ended.
- R6: Divisor code 2 silences that tone: its sign output stays 0 while the other tone runs.
- R7: Divisor codes 0 and 1 act as 257 for the high tone (half period 771 cycles) and as 256 for the low tone (half period 1792 cycles).
- R8: A divisor rewritten while its tone runs applies from that tone's last toggle point. The running count is not restarted, so no phase step occurs.
- R9: `level` equals the number of sign outputs at 1 (0, 1 or 2). It is never 3.
- R10: Reset drives both sign outputs and `level` to 0, clears the timer and both divisors, and leaves the tones idle until the low register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.2 MHz system clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrHigh | input | 1 | Write strobe for the high-tone divisor |
| wrLow | input | 1 | Write strobe for the low-tone divisor; starts a burst |
| wrData | input | DIV_W | Divisor code for either write |
| contMode | input | 1 | 1 = tones run without the burst limit |
| toneHi | output | 1 | High-tone square wave (sign) |
| toneLo | output | 1 | Low-tone square wave (sign) |
| level | output | 2 | Sum of the two sign outputs |

## Verification
A wrong divide count or a wrongly decoded special code moves a tone's very first toggle away from its predicted cycle. That shows at the port within one half period of the starting write. A timer that ends one cycle early or late, or a stop rule that misses the toggle point, shows as a missing, extra or misplaced edge at the end of a burst. A counter restarted on a divisor rewrite moves the next edge of that tone at once, so every sign edge is compared with a precomputed cycle and value.

// File: rtl/dtone_pkg.sv
package dtone_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic start;     // begin any idle tone
    logic stopReq;   // end each tone at its next toggle point
    logic silentHi;  // high divisor code silences the tone
    logic silentLo;  // low divisor code silences the tone
  } toneStrobe_t;

  function automatic int unsigned maxHalf(int unsigned hiPre, int unsigned loPre,
                                          int unsigned divW);
    int unsigned hiMax;
    int unsigned loMax;
    hiMax = (hiPre / 2) * ((32'd1 << divW) + 1);
    loMax = (loPre / 2) * (32'd1 << divW);
    return (hiMax > loMax) ? hiMax : loMax;
  endfunction

endpackage

// File: rtl/dtone_ctrl.sv
module dtone_ctrl
  import dtone_pkg::*;
#(
  parameter int unsigned DIV_W        = 8,
  parameter int unsigned HI_PRE       = 6,
  parameter int unsigned LO_PRE       = 14,
  parameter int unsigned BURST_CYCLES = 115200,
  parameter int unsigned HALF_W       = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrHigh,
  input  logic              wrLow,
  input  logic [DIV_W-1:0]  wrData,
  input  logic              contMode,
  output toneStrobe_t       strobe,
  output logic [HALF_W-1:0] halfHi,
  output logic [HALF_W-1:0] halfLo
);
  localparam int unsigned TMR_W   = (BURST_CYCLES > 1) ? $clog2(BURST_CYCLES) : 1;
  localparam int unsigned HI_WRAP = (32'd1 << DIV_W) + 1;
  localparam int unsigned LO_WRAP = (32'd1 << DIV_W);

  logic [DIV_W-1:0] hdReg, ldReg;
  logic [DIV_W:0]   effHi, effLo;
  logic [TMR_W-1:0] tmr;
  logic             burstOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdReg <= '0;
      ldReg <= '0;
    end else begin
      if (wrHigh) hdReg <= wrData;
      if (wrLow)  ldReg <= wrData;
    end
  end

  // burst window: a low write reloads it, then it counts down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn <= 1'b0;
      tmr     <= '0;
    end else if (wrLow) begin
      burstOn <= 1'b1;
      tmr     <= TMR_W'(BURST_CYCLES - 1);
    end else if (burstOn) begin
      if (tmr == '0) burstOn <= 1'b0;
      else           tmr     <= tmr - 1'b1;
    end
  end

  // special codes: 0 and 1 pick the long period
  always_comb begin
    effHi  = (hdReg <= DIV_W'(1)) ? (DIV_W+1)'(HI_WRAP) : {1'b0, hdReg};
    effLo  = (ldReg <= DIV_W'(1)) ? (DIV_W+1)'(LO_WRAP) : {1'b0, ldReg};
    halfHi = HALF_W'((HI_PRE / 2) * 32'(effHi));
    halfLo = HALF_W'((LO_PRE / 2) * 32'(effLo));
  end

  assign strobe.start    = wrLow;
  assign strobe.stopReq  = !burstOn && !contMode;
  assign strobe.silentHi = (hdReg == DIV_W'(2));
  assign strobe.silentLo = (ldReg == DIV_W'(2));

endmodule

// File: rtl/dtone_core.sv
module dtone_core #(
  parameter int unsigned HALF_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              stopReq,
  input  logic              silent,
  input  logic [HALF_W-1:0] half,
  output logic              sign
);
  logic              running;
  logic [HALF_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      sign    <= 1'b0;
    end else if (!running) begin
      running <= start;
      cnt     <= '0;
      sign    <= 1'b0;
    end else if (silent) begin
      // a silent tone has no crossings, so it ends as soon as asked
      cnt  <= '0;
      sign <= 1'b0;
      if (stopReq) running <= 1'b0;
    end else if (cnt >= half - HALF_W'(1)) begin
      // toggle point; ">=" keeps a shortened divisor phase-safe
      cnt <= '0;
      if (stopReq) begin
        running <= 1'b0;
        sign    <= 1'b0;
      end else begin
        sign <= ~sign;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dtone_datapath.sv
module dtone_datapath
  import dtone_pkg::*;
#(
  parameter int unsigned HALF_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  toneStrobe_t       strobe,
  input  logic [HALF_W-1:0] halfHi,
  input  logic [HALF_W-1:0] halfLo,
  output logic              toneHi,
  output logic              toneLo,
  output logic [1:0]        level
);
  localparam int unsigned N_TONES = 2;

  logic [HALF_W-1:0] halfArr [N_TONES];
  logic [N_TONES-1:0] silentArr;
  logic [N_TONES-1:0] signArr;

  assign halfArr[0]   = halfHi;
  assign halfArr[1]   = halfLo;
  assign silentArr[0] = strobe.silentHi;
  assign silentArr[1] = strobe.silentLo;

  for (genvar i = 0; i < N_TONES; i++) begin : g_tone
    dtone_core #(.HALF_W(HALF_W)) u_core (
      .clk    (clk),
      .rstN   (rstN),
      .start  (strobe.start),
      .stopReq(strobe.stopReq),
      .silent (silentArr[i]),
      .half   (halfArr[i]),
      .sign   (signArr[i])
    );
  end

  assign toneHi = signArr[0];
  assign toneLo = signArr[1];
  assign level  = {1'b0, signArr[0]} + {1'b0, signArr[1]};

endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen
  import dtone_pkg::*;
#(
  parameter int unsigned DIV_W        = 8,
  parameter int unsigned HI_PRE       = 6,
  parameter int unsigned LO_PRE       = 14,
  parameter int unsigned BURST_CYCLES = 115200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrHigh,
  input  logic             wrLow,
  input  logic [DIV_W-1:0] wrData,
  input  logic             contMode,
  output logic             toneHi,
  output logic             toneLo,
  output logic [1:0]       level
);
  localparam int unsigned HALF_W = $clog2(maxHalf(HI_PRE, LO_PRE, DIV_W) + 1);

  toneStrobe_t       strobe;
  logic [HALF_W-1:0] halfHi, halfLo;

  dtone_ctrl #(
    .DIV_W(DIV_W), .HI_PRE(HI_PRE), .LO_PRE(LO_PRE),
    .BURST_CYCLES(BURST_CYCLES), .HALF_W(HALF_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrHigh(wrHigh), .wrLow(wrLow),
    .wrData(wrData), .contMode(contMode),
    .strobe(strobe), .halfHi(halfHi), .halfLo(halfLo)
  );

  dtone_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .halfHi(halfHi), .halfLo(halfLo),
    .toneHi(toneHi), .toneLo(toneLo), .level(level)
  );

endmodule

// File: rtl/dual_tone_gen_chk.sv
module dual_tone_gen_chk #(
  parameter int unsigned DIV_W        = 8,
  parameter int unsigned BURST_CYCLES = 115200
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrHigh,
  input logic             wrLow,
  input logic [DIV_W-1:0] wrData,
  input logic             contMode,
  input logic             toneHi,
  input logic             toneLo,
  input logic [1:0]       level
);
  logic        started;
  logic        hiSil, hiSilD, loSil, loSilD;
  int unsigned left;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      hiSil   <= 1'b0;
      hiSilD  <= 1'b0;
      loSil   <= 1'b0;
      loSilD  <= 1'b0;
      left    <= 0;
    end else begin
      if (wrLow) started <= 1'b1;
      if (wrHigh) hiSil <= (wrData == DIV_W'(2));
      if (wrLow)  loSil <= (wrData == DIV_W'(2));
      hiSilD <= hiSil;
      loSilD <= loSil;
      if (wrLow)          left <= BURST_CYCLES;
      else if (left != 0) left <= left - 1;
    end
  end

  // R10: nothing sounds before the first low write
  p_idle_until_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> (!toneHi && !toneLo));

  // R9: level word agrees with the two signs
  p_level_both_r9: assert property (@(posedge clk) disable iff (!rstN)
    (toneHi && toneLo) |-> (level == 2'd2));
  p_level_none_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!toneHi && !toneLo) |-> (level == 2'd0));
  p_level_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    level != 2'd3);

  // R6: a silenced tone stays low
  p_silent_hi_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hiSil && hiSilD) |-> !toneHi);
  p_silent_lo_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loSil && loSilD) |-> !toneLo);

  // R3/R5: a sign may rise only inside a burst or in continuous mode
  p_rise_in_burst_hi_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toneHi) |-> $past((left != 0) || contMode));
  p_rise_in_burst_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toneLo) |-> $past((left != 0) || contMode));

endmodule

bind dual_tone_gen dual_tone_gen_chk #(
  .DIV_W(DIV_W), .BURST_CYCLES(BURST_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .wrHigh(wrHigh), .wrLow(wrLow), .wrData(wrData),
  .contMode(contMode), .toneHi(toneHi), .toneLo(toneLo), .level(level)
);

// File: tb/dual_tone_gen_bench.sv
module dual_tone_gen_bench;
  localparam int BURST = 1000;
  localparam int BIG   = 1 << 30;

  typedef struct {
    int    t;
    bit    v;
    string req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrHigh = 1'b0, wrLow = 1'b0, contMode = 1'b0;
  logic [7:0] wrData = '0;
  logic       toneHi, toneLo;
  logic [1:0] level;

  int  cyc = 0;
  int  nChecks = 0, nBad = 0;
  bit  finished = 0;
  bit  prevHi = 0, prevLo = 0;
  ev_t qHi[$];
  ev_t qLo[$];
  ev_t evHi, evLo;

  dual_tone_gen #(.BURST_CYCLES(BURST)) u_dual_tone_gen (
    .clk(clk), .rstN(rstN), .wrHigh(wrHigh), .wrLow(wrLow), .wrData(wrData),
    .contMode(contMode), .toneHi(toneHi), .toneLo(toneLo), .level(level)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: every sign edge must match the head of its queue
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (toneHi !== prevHi) begin
        if (qHi.size() == 0) check(0, "R4", "unexpected high edge at cycle", cyc, -1);
        else begin
          evHi = qHi.pop_front();
          check(evHi.t == cyc, evHi.req, "high edge cycle", cyc, evHi.t);
          check(toneHi == evHi.v, evHi.req, "high edge value", int'(toneHi), int'(evHi.v));
        end
        check(level == 2'(toneHi) + 2'(toneLo), "R9", "level at high edge",
              int'(level), int'(toneHi) + int'(toneLo));
      end
      if (toneLo !== prevLo) begin
        if (qLo.size() == 0) check(0, "R4", "unexpected low edge at cycle", cyc, -1);
        else begin
          evLo = qLo.pop_front();
          check(evLo.t == cyc, evLo.req, "low edge cycle", cyc, evLo.t);
          check(toneLo == evLo.v, evLo.req, "low edge value", int'(toneLo), int'(evLo.v));
        end
        check(level == 2'(toneHi) + 2'(toneLo), "R9", "level at low edge",
              int'(level), int'(toneHi) + int'(toneLo));
      end
    end
    prevHi = toneHi;
    prevLo = toneLo;
  end

  task automatic push(input bit hi, input int t, input bit v, input string req);
    ev_t e;
    e.t = t; e.v = v; e.req = req;
    if (hi) qHi.push_back(e);
    else    qLo.push_back(e);
  endtask

  // expected edges: toggles every half cycles from t0; first event at or
  // after stopAt ends the tone low; events past tMax are left for later
  task automatic planTone(input bit hi, input int t0, input int half, input int tMax,
                          input int stopAt, input string req, inout bit cur,
                          output int tLast);
    bit done = 0;
    int t = t0;
    tLast = t0;
    while (!done) begin
      t += half;
      if (t >= stopAt) begin
        if (cur) push(hi, t, 1'b0, "R4");
        cur  = 0;
        done = 1;
      end else if (t > tMax) begin
        done = 1;
      end else begin
        cur = ~cur;
        push(hi, t, cur, req);
        tLast = t;
      end
    end
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // called at a negedge; returns the edge that samples the write
  task automatic writeReg(input bit isLow, input int v, output int tEdge);
    wrData = 8'(v);
    wrHigh = !isLow;
    wrLow  = isLow;
    tEdge  = cyc + 1;
    @(negedge clk);
    wrHigh = 0;
    wrLow  = 0;
  endtask

  task automatic checkDrained(input string req);
    check(qHi.size() == 0, req, "pending high edges", qHi.size(), 0);
    check(qLo.size() == 0, req, "pending low edges", qLo.size(), 0);
    check(!toneHi && !toneLo, req, "signs after stop", int'({toneHi, toneLo}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "R3", "watchdog expired at cycle", cyc, 0);
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    int  e0, tw, tLast, cMark, dummy;
    bit  curHi, curLo;

    repeat (3) @(negedge clk);
    // R10: reset state
    check(toneHi == 0 && toneLo == 0, "R10", "signs in reset", int'({toneHi, toneLo}), 0);
    check(level == 0, "R10", "level in reset", int'(level), 0);
    rstN = 1;
    @(negedge clk);

    // R3: a high write alone never starts a tone
    writeReg(0, 10, tw);
    waitUntil(tw + 200);
    check(toneHi == 0 && toneLo == 0, "R3", "signs after high write only",
          int'({toneHi, toneLo}), 0);

    // burst: R1 (H=10 -> 30), R2 (L=20 -> 140), R3 window, R4 stop
    writeReg(1, 20, e0);
    curHi = 0; curLo = 0;
    planTone(1, e0, 30,  BIG, e0 + BURST + 1, "R1", curHi, dummy);
    planTone(0, e0, 140, BIG, e0 + BURST + 1, "R2", curLo, dummy);
    waitUntil(e0 + 1400);
    checkDrained("R3");

    // R5 continuous past the burst, R8 phase-continuous rewrite
    contMode = 1;
    writeReg(1, 20, e0);
    cMark = e0 + 1600;
    curHi = 0; curLo = 0;
    planTone(1, e0, 30, e0 + 600, BIG, "R1", curHi, tLast);
    planTone(0, e0, 140, BIG, cMark, "R5", curLo, dummy);
    waitUntil(tLast + 4);
    writeReg(0, 16, tw);
    planTone(1, tLast, 48, BIG, cMark, "R8", curHi, dummy);
    waitUntil(cMark - 1);
    contMode = 0;
    waitUntil(cMark + 300);
    checkDrained("R5");

    // R6 high silenced, R7 low code 0 -> half 1792
    contMode = 1;
    writeReg(0, 2, tw);
    writeReg(1, 0, e0);
    cMark = e0 + 4000;
    curLo = 0;
    planTone(0, e0, 1792, BIG, cMark, "R7", curLo, dummy);
    waitUntil(e0 + 2000);
    check(toneHi == 0, "R6", "silenced high tone", int'(toneHi), 0);
    waitUntil(cMark - 1);
    contMode = 0;
    waitUntil(cMark + 1900);
    checkDrained("R7");

    // R7 high code 1 -> half 771, R6 low silenced
    contMode = 1;
    writeReg(0, 1, tw);
    writeReg(1, 2, e0);
    cMark = e0 + 3000;
    curHi = 0;
    planTone(1, e0, 771, BIG, cMark, "R7", curHi, dummy);
    waitUntil(e0 + 1000);
    check(toneLo == 0, "R6", "silenced low tone", int'(toneLo), 0);
    check(level == 2'(toneHi), "R9", "level with one tone", int'(level), int'(toneHi));
    waitUntil(cMark - 1);
    contMode = 0;
    waitUntil(cMark + 900);
    checkDrained("R6");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule